// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address stream for a four-beat memory burst. A host starts a burst by raising either of two start strobes, one meant for the processor side and one for the memory-controller side. Either strobe captures the full external address. From then on the two low address bits step through the burst once per cycle in which the advance input is high. The upper address bits do not move until the next start.

The stepping order is linear (add one, wrap within the group of four) or interleaved (the start offset XORed with a running beat count). The order is captured from a select input at the start of each burst, so changing the select mid-burst has no effect. When the select pin is not wired (parameter `ORDER_PIN_EN = 0`), the order is fixed by the parameter `DEFAULT_ORDER`, which is interleaved by default. Bursts are optional: a host may start with a fresh address on every cycle. The current address is a function of registered state only, so it is stable for the whole clock period.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `cur_addr` is zero.
- R2: A cycle with `strt_cpu` high makes `cur_addr` equal to `ext_addr` after that clock edge.
- R3: A cycle with `strt_ctl` high makes `cur_addr` equal to `ext_addr` after that clock edge.
- R4: In linear order (`order_lin` = 1 at the start), the low two bits after k advances equal (start low bits + k) modulo 4.
- R5: In interleaved order (`order_lin` = 0 at the start), the low two bits after k advances equal the start low bits XOR (k modulo 4).
- R6: Advances never change `cur_addr[ADDR_W-1:2]`.
- R7: A cycle with no strobe and `adv` low leaves `cur_addr` unchanged.
- R8: When a strobe and `adv` are high in the same cycle, the load takes effect and the advance is discarded.
- R9: After four advances, `cur_addr` is back at the start address, and later advances continue the same cycle.
- R10: `order_lin` is sampled only in a start cycle. Changing it during a burst does not alter the sequence.
- R11: With `ORDER_PIN_EN` = 0, every burst uses `DEFAULT_ORDER` (interleaved by default) whatever `order_lin` does.
- R12: A strobe in consecutive cycles loads a new address each cycle, with no lost or delayed address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| strt_cpu | input | 1 | Processor-side burst start strobe |
| strt_ctl | input | 1 | Controller-side burst start strobe |
| adv | input | 1 | Advance to the next beat of the burst |
| order_lin | input | 1 | Order select captured at start: 1 linear, 0 interleaved |
| ext_addr | input | ADDR_W | Address captured at a start |
| cur_addr | output | ADDR_W | Current burst address |

## Verification
The bench builds two copies of the block with `ADDR_W = 12`, both driven by the same stimulus. One has the order pin enabled, so linear and interleaved sequences and mid-burst changes of the select can be exercised. The other has the pin disabled, which shows that the interleaved default holds while the select input toggles. The narrow address keeps the upper field small, so random loads often repeat upper values and land on every start offset.

// File: rtl/burst_pkg.sv
package burst_pkg;

    // Beat counter width: four beats per burst
    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_ILV = 1'b0,
        ORD_LIN = 1'b1
    } burst_order_e;

    typedef struct packed {
        beat_t        start;
        beat_t        cnt;
        burst_order_e order;
    } burst_state_t;

    // Low address bits for a given start offset and beat count
    function automatic beat_t beat_low(beat_t start, beat_t cnt, burst_order_e ord);
        beat_t r;
        if (ord == ORD_LIN) r = start + cnt;
        else                r = start ^ cnt;
        return r;
    endfunction

endpackage

// File: rtl/burst_order_sel.sv
module burst_order_sel
    import burst_pkg::*;
#(
    parameter bit           PIN_EN  = 1'b1,
    parameter burst_order_e DEF_ORD = ORD_ILV
) (
    input  logic         order_pin,
    output burst_order_e order
);
    generate
        if (PIN_EN) begin : g_pin
            assign order = order_pin ? ORD_LIN : ORD_ILV;
        end else begin : g_fixed
            logic pin_unused;
            assign pin_unused = order_pin;
            assign order      = DEF_ORD;
        end
    endgenerate
endmodule

// File: rtl/burst_counter.sv
module burst_counter
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20,
    localparam int UP_W  = ADDR_W - BEAT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               adv,
    input  logic [ADDR_W-1:0]  load_addr,
    input  burst_order_e       order,
    output logic [UP_W-1:0]    upper_q,
    output burst_state_t       st_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            st_q    <= '{start: '0, cnt: '0, order: ORD_ILV};
        end else if (load) begin
            upper_q <= load_addr[ADDR_W-1:BEAT_W];
            st_q    <= '{start: load_addr[BEAT_W-1:0], cnt: '0, order: order};
        end else if (adv) begin
            st_q.cnt <= st_q.cnt + 1'b1;
        end
    end

    // R6
    upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(upper_q));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv) |=> $stable(st_q));

    // R9
    beat_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load) |=> st_q.cnt == beat_t'($past(st_q.cnt) + 1'b1));

    // R10
    order_latch_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(st_q.order));

    // R8
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> st_q.cnt == '0);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int           ADDR_W        = 20,
    parameter bit           ORDER_PIN_EN  = 1'b1,
    parameter burst_order_e DEFAULT_ORDER = ORD_ILV,
    localparam int          UP_W          = ADDR_W - BEAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strt_cpu,
    input  logic              strt_ctl,
    input  logic              adv,
    input  logic              order_lin,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    logic          load;
    burst_order_e  order_in;
    logic [UP_W-1:0] upper_q;
    burst_state_t  st_q;

    assign load = strt_cpu | strt_ctl;

    burst_order_sel #(
        .PIN_EN  (ORDER_PIN_EN),
        .DEF_ORD (DEFAULT_ORDER)
    ) u_sel (
        .order_pin (order_lin),
        .order     (order_in)
    );

    burst_counter #(
        .ADDR_W (ADDR_W)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .adv       (adv),
        .load_addr (ext_addr),
        .order     (order_in),
        .upper_q   (upper_q),
        .st_q      (st_q)
    );

    assign cur_addr = {upper_q, beat_low(st_q.start, st_q.cnt, st_q.order)};

    // R2 R3 R12
    load_addr_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> cur_addr == $past(ext_addr));

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> cur_addr == '0);
endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strt_cpu = 1'b0, strt_ctl = 1'b0, adv = 1'b0, order_lin = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] addr_pin, addr_def;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // model state
    logic [AW-3:0] m_up = '0;
    logic [1:0]    m_st = '0, m_cnt = '0;
    logic          m_lin = 1'b0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .ORDER_PIN_EN(1'b1)) dut_i (
        .clk(clk), .rst(rst), .strt_cpu(strt_cpu), .strt_ctl(strt_ctl),
        .adv(adv), .order_lin(order_lin), .ext_addr(ext_addr), .cur_addr(addr_pin));

    burst_addr_gen #(.ADDR_W(AW), .ORDER_PIN_EN(1'b0)) dut_def (
        .clk(clk), .rst(rst), .strt_cpu(strt_cpu), .strt_ctl(strt_ctl),
        .adv(adv), .order_lin(order_lin), .ext_addr(ext_addr), .cur_addr(addr_def));

    function automatic logic [AW-1:0] exp_addr(logic lin);
        logic [1:0] lo;
        lo = lin ? 2'(m_st + m_cnt) : (m_st ^ m_cnt);
        return {m_up, lo};
    endfunction

    task automatic cmp(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R11 is checked on dut_def in every step
    task automatic step(string tag, logic c, logic k, logic a, logic [AW-1:0] ad, logic ol);
        @(negedge clk);
        strt_cpu = c; strt_ctl = k; adv = a; ext_addr = ad; order_lin = ol;
        @(posedge clk);
        if (c | k) begin
            m_up = ad[AW-1:2]; m_st = ad[1:0]; m_cnt = '0; m_lin = ol;
        end else if (a) begin
            m_cnt = m_cnt + 2'd1;
        end
        #1;
        cmp(tag, addr_pin, exp_addr(m_lin));
        cmp("R11", addr_def, exp_addr(1'b0));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below 100000", cyc);
            summary();
        end
    end

    initial begin
        void'($urandom(32'h1bad5eed));
        repeat (3) @(posedge clk);
        #1;
        cmp("R1", addr_pin, '0);
        cmp("R1", addr_def, '0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        cmp("R1", addr_pin, '0);

        // R2 linear burst from offset 1, then wrap (R4, R6, R9)
        step("R2", 1, 0, 0, 12'hA5D, 1);
        step("R4", 0, 0, 1, 12'h000, 1);
        step("R4", 0, 0, 1, 12'hFFF, 0);
        step("R6", 0, 0, 1, 12'h123, 1);
        step("R9", 0, 0, 1, 12'h000, 1);
        step("R9", 0, 0, 1, 12'h000, 1);
        // R7 hold
        step("R7", 0, 0, 0, 12'h777, 0);
        step("R7", 0, 0, 0, 12'h888, 1);
        // R3 interleaved from offset 1: 1,0,3,2 (R5), order flips mid-burst (R10)
        step("R3", 0, 1, 0, 12'h3C1, 0);
        step("R5", 0, 0, 1, 12'h000, 1);
        step("R10", 0, 0, 1, 12'h000, 1);
        step("R10", 0, 0, 1, 12'h000, 0);
        step("R9", 0, 0, 1, 12'h000, 1);
        // R8 load with advance
        step("R8", 1, 0, 1, 12'h6B2, 1);
        step("R8", 0, 1, 1, 12'h6B3, 0);
        step("R8", 1, 1, 1, 12'h0FE, 1);
        // R12 back-to-back loads
        for (int i = 0; i < 8; i++)
            step("R12", i[0], ~i[0], 0, AW'(12'h101 * (i + 1)), i[1]);

        // constrained random: strobes rare, advance frequent
        for (int i = 0; i < 3000; i++) begin
            logic s;
            logic [3:0] r;
            r = 4'($urandom_range(0, 15));
            s = (r < 4'd3);
            step(m_lin ? "R4" : "R5", s & r[0], s & ~r[0], ($urandom_range(0, 3) != 0),
                 AW'($urandom), 1'($urandom));
        end

        // reset mid-burst
        @(negedge clk); rst = 1'b1; strt_cpu = 0; strt_ctl = 0; adv = 1;
        @(posedge clk); #1;
        cmp("R1", addr_pin, '0);
        cmp("R1", addr_def, '0);
        summary();
    end
endmodule